// File: doc/BRIEF.md
# Receive Byte Queue with Fill Trigger and Idle Timeout

This block buffers received characters for one serial receive channel. Each stored entry holds an 8-bit character and three error bits that the receiver reports alongside it. The host reads the oldest entry from `rd_data`/`rd_err` and removes it with `rd_en`. Two conditions call for the host. `ready` is high while the fill level is at or above a threshold that the control byte selects from four values. `timeout` is high when data has been waiting for four character times and nothing has moved in the meantime. The timeout covers data that never reaches the threshold.

The control byte `ctl` is a held input. Bit 0 selects buffered mode, with 16 entries. With bit 0 clear the block acts as a single holding register. Bit 1 empties the queue while it is high. Bits 7:6 select the threshold. `char_tick` is a one-cycle pulse supplied once per character time by the baud logic outside this block.

The idle timer is a three-state machine. T_IDLE: nothing is waiting. It moves to T_COUNT when buffered mode is on, the level is non-zero and no flush is active. T_COUNT counts character ticks. It returns to T_IDLE when the queue empties, is flushed or leaves buffered mode. A received strobe or a read clears its count. It moves to T_FIRED on the fourth uncleared tick. T_FIRED drives `timeout`. A read moves it to T_COUNT, or to T_IDLE when the queue is no longer active. A flush or a mode change moves it to T_IDLE. New characters leave it in T_FIRED.

Top module: `rxq_buffer`

## Requirements
- R1: After reset `level` is 0 and `ready`, `timeout` and `overrun` are 0.
- R2: In buffered mode (ctl bit 0 = 1) up to 16 entries are held and returned oldest first. Each entry returns its 3 error bits with its byte. `rd_data`/`rd_err` show the oldest entry, and `rd_en` removes it at the clock edge.
- R3: A character arriving when the queue is at capacity is discarded, even if a read happens in the same cycle. This sets `overrun`, which then stays high until a flush.
- R4: Threshold select ctl[7:6] is decoded as 00 = 1, 01 = 4, 10 = 8 and 11 = 14 entries. `ready` is high exactly while `level` is at or above the threshold, so it drops in the cycle the level falls below it.
- R5: In holding mode (ctl bit 0 = 0) capacity is one entry and `ready` is high at level 1. A second character is discarded with `overrun` set. `timeout` never asserts in this mode.
- R6: While ctl bit 1 is high the queue is emptied and `overrun` cleared, and the threshold setting is kept. A change of ctl bit 0 also empties the queue.
- R7: In buffered mode with data waiting, `timeout` rises in the cycle after the fourth `char_tick` counted since the last restart.
- R8: An `rx_valid` or `rd_en` strobe restarts the character count. A tick in the same cycle as such a strobe is not counted.
- R9: `timeout` stays high while further characters arrive. It falls in the cycle after a read.
- R10: `rd_en` while the queue is empty has no effect on level or contents.
- R11: Except on a flush, `level` changes by at most one per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl | input | 8 | Control: bit 0 buffered mode, bit 1 flush, bits 7:6 threshold |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_err | input | 3 | Error bits for the received character |
| rd_en | input | 1 | Host read strobe; removes the oldest entry |
| char_tick | input | 1 | One pulse per character time |
| rd_data | output | 8 | Oldest character, 0 when empty |
| rd_err | output | 3 | Error bits of the oldest character, 0 when empty |
| level | output | 5 | Number of stored entries |
| ready | output | 1 | Level at or above the threshold |
| timeout | output | 1 | Character idle timeout |
| overrun | output | 1 | Sticky: a character was discarded |

## Verification
On every cycle the assertions check these properties:
- `level` stays within capacity and steps by at most one.
- `overrun` holds until a flush.
- A discard at full capacity raises `overrun`.
- `timeout` only occurs while data is waiting.
- `timeout` only rises just after a character tick.

Only the bench scenarios can show:
- arrival order and error-bit pairing;
- the exact threshold values;
- the fourth-tick timing and its restart on reads and arrivals;
- the holding-mode behaviour.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        T_IDLE  = 2'd0,
        T_COUNT = 2'd1,
        T_FIRED = 2'd2
    } tmr_state_t;

    // Threshold decode for the ready flag, scaled from the queue depth.
    function automatic int unsigned thr_of(input logic [1:0] sel, input int unsigned depth);
        unique case (sel)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int EW    = 3,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_en,
    input  logic          flush_req,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic [EW-1:0] wr_err,
    input  logic          rd_req,
    output logic [DW-1:0] head_data,
    output logic [EW-1:0] head_err,
    output logic [LW-1:0] level,
    output logic          popped,
    output logic          flushing,
    output logic          overrun
);

    logic [DW+EW-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             en_q;
    logic [LW-1:0]    cap;
    logic             wr_ok;

    assign flushing = flush_req || (buf_en != en_q);
    assign cap      = buf_en ? LW'(DEPTH) : LW'(1);
    assign wr_ok    = wr_req && !flushing && (level < cap);
    assign popped   = rd_req && !flushing && (level != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            en_q    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            en_q <= buf_en;
            if (flushing) begin
                wr_ptr  <= '0;
                rd_ptr  <= '0;
                level   <= '0;
                overrun <= 1'b0;
            end else begin
                if (wr_req && (level >= cap))
                    overrun <= 1'b1;
                if (wr_ok)
                    wr_ptr <= wr_ptr + 1'b1;
                if (popped)
                    rd_ptr <= rd_ptr + 1'b1;
                unique case ({wr_ok, popped})
                    2'b10:   level <= level + 1'b1;
                    2'b01:   level <= level - 1'b1;
                    default: level <= level;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok)
            mem[wr_ptr] <= {wr_err, wr_data};
    end

    always_comb begin
        if (level != '0) begin
            {head_err, head_data} = mem[rd_ptr];
        end else begin
            head_err  = '0;
            head_data = '0;
        end
    end

endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger #(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          buf_en,
    input  logic [1:0]    sel,
    input  logic [LW-1:0] level,
    output logic          ready
);
    import rxq_pkg::*;

    logic [LW-1:0] thr;

    always_comb begin
        if (buf_en)
            thr = LW'(thr_of(sel, DEPTH));
        else
            thr = LW'(1);
        ready = (level >= thr);
    end

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
    parameter int TO_CHARS = 4,
    localparam int CW      = $clog2(TO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic restart,
    input  logic popped,
    input  logic tick,
    output logic timeout
);
    import rxq_pkg::*;

    tmr_state_t    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= T_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            T_IDLE: begin
                cnt_nx = '0;
                if (active)
                    state_nx = T_COUNT;
            end
            T_COUNT: begin
                if (!active) begin
                    state_nx = T_IDLE;
                    cnt_nx   = '0;
                end else if (restart) begin
                    cnt_nx = '0;
                end else if (tick) begin
                    if (cnt == CW'(TO_CHARS - 1)) begin
                        state_nx = T_FIRED;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            T_FIRED: begin
                cnt_nx = '0;
                if (!active)
                    state_nx = T_IDLE;
                else if (popped)
                    state_nx = T_COUNT;
            end
            default: begin
                state_nx = T_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        timeout = (state == T_FIRED);
    end

endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer #(
    parameter int DEPTH    = 16,
    parameter int DW       = 8,
    parameter int EW       = 3,
    parameter int TO_CHARS = 4,
    localparam int LW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    ctl,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic [EW-1:0] rx_err,
    input  logic          rd_en,
    input  logic          char_tick,
    output logic [DW-1:0] rd_data,
    output logic [EW-1:0] rd_err,
    output logic [LW-1:0] level,
    output logic          ready,
    output logic          timeout,
    output logic          overrun
);

    logic buf_en, popped, flushing, tmr_active, tmr_restart;

    assign buf_en = ctl[0];

    rxq_store #(.DEPTH(DEPTH), .DW(DW), .EW(EW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_en    (buf_en),
        .flush_req (ctl[1]),
        .wr_req    (rx_valid),
        .wr_data   (rx_data),
        .wr_err    (rx_err),
        .rd_req    (rd_en),
        .head_data (rd_data),
        .head_err  (rd_err),
        .level     (level),
        .popped    (popped),
        .flushing  (flushing),
        .overrun   (overrun)
    );

    rxq_trigger #(.DEPTH(DEPTH)) u_trig (
        .buf_en (buf_en),
        .sel    (ctl[7:6]),
        .level  (level),
        .ready  (ready)
    );

    assign tmr_active  = buf_en && !flushing && (level != '0);
    assign tmr_restart = rx_valid || popped;

    rxq_idle_timer #(.TO_CHARS(TO_CHARS)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (tmr_active),
        .restart (tmr_restart),
        .popped  (popped),
        .tick    (char_tick),
        .timeout (timeout)
    );

endmodule

// File: rtl/rxq_buffer_chk.sv
module rxq_buffer_chk #(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    ctl,
    input logic          rx_valid,
    input logic          rd_en,
    input logic          char_tick,
    input logic [LW-1:0] level,
    input logic          timeout,
    input logic          overrun
);

    p_capacity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= LW'(DEPTH)));

    p_overrun_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ctl[1] && (ctl[0] == $past(ctl[0]))) |=> overrun);

    p_full_discard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[0] && (ctl[0] == $past(ctl[0])) && !ctl[1] && rx_valid && (level == LW'(DEPTH)))
        |=> (overrun && level <= LW'(DEPTH)));

    p_no_to_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (level != '0));

    p_to_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(char_tick));

    p_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[1] |=> ((level == $past(level)) || (level == $past(level) + 1'b1)
                     || (level + 1'b1 == $past(level)) || (level == '0)));

endmodule

bind rxq_buffer rxq_buffer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .rx_valid  (rx_valid),
    .rd_en     (rd_en),
    .char_tick (char_tick),
    .level     (level),
    .timeout   (timeout),
    .overrun   (overrun)
);

// File: tb/rxq_buffer_bench.sv
module rxq_buffer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctl = 8'h01;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic [2:0] rx_err = '0;
    logic       rd_en = 1'b0;
    logic       char_tick = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] rd_err;
    logic [4:0] level;
    logic       ready, timeout, overrun;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    rxq_buffer u_rxq_buffer (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err(rx_err), .rd_en(rd_en), .char_tick(char_tick), .rd_data(rd_data),
        .rd_err(rd_err), .level(level), .ready(ready), .timeout(timeout), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] e);
        rx_valid = 1'b1; rx_data = d; rx_err = e;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pop_expect(input logic [7:0] d, input logic [2:0] e, input string req);
        check(rd_data == d, req, rd_data, d);
        check(rd_err == e, req, rd_err, e);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick();
        char_tick = 1'b1;
        @(negedge clk);
        char_tick = 1'b0;
    endtask

    task automatic flush(input logic [7:0] base);
        ctl = base | 8'h02;
        @(negedge clk);
        ctl = base;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(level == 0, "R1 level", level, 0);
        check(ready == 0, "R1 ready", ready, 0);
        check(timeout == 0, "R1 timeout", timeout, 0);
        check(overrun == 0, "R1 overrun", overrun, 0);
    endtask

    task automatic t_order_full();
        flush(8'hC1);
        for (int i = 0; i < 16; i++) push(8'h30 + 8'(i), 3'(i));
        check(level == 16, "R2 level full", level, 16);
        check(overrun == 0, "R2 no overrun", overrun, 0);
        push(8'hEE, 3'd7); // R3 discarded
        check(level == 16, "R3 level stays", level, 16);
        check(overrun == 1, "R3 overrun set", overrun, 1);
        // R3 write with a read in the same cycle at full is still discarded
        rx_valid = 1'b1; rx_data = 8'hDD; rx_err = 3'd7; rd_en = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rd_en = 1'b0;
        check(level == 15, "R3 full write with read", level, 15);
        for (int i = 1; i < 16; i++) pop_expect(8'h30 + 8'(i), 3'(i), "R2 order");
        check(level == 0, "R2 drained", level, 0);
        check(overrun == 1, "R3 sticky", overrun, 1);
        flush(8'hC1);
        check(overrun == 0, "R6 flush clears overrun", overrun, 0);
    endtask

    task automatic t_thresholds();
        int thr_tab [4] = '{1, 4, 8, 14};
        for (int s = 0; s < 4; s++) begin
            logic [7:0] base;
            base = {2'(s), 6'b000001};
            flush(base);
            for (int k = 1; k <= thr_tab[s]; k++) begin
                push(8'(k), 3'd0);
                check(ready == (k >= thr_tab[s]), "R4 ready vs level", ready, int'(k >= thr_tab[s]));
            end
            pop_expect(8'd1, 3'd0, "R4 head");
            check(ready == 0, "R4 ready drops below", ready, 0);
        end
        flush(8'h01);
    endtask

    task automatic t_flush_keeps_sel();
        flush(8'h41);
        for (int k = 0; k < 3; k++) push(8'hA0, 3'd1);
        flush(8'h41);
        check(level == 0, "R6 flush empties", level, 0);
        for (int k = 0; k < 4; k++) push(8'hA1, 3'd1);
        check(ready == 1, "R6 threshold kept", ready, 1);
        ctl = 8'h40; // leave buffered mode: R6 empties
        @(negedge clk);
        check(level == 0, "R6 mode change empties", level, 0);
    endtask

    task automatic t_holding();
        ctl = 8'h00;
        idle(2);
        push(8'h5A, 3'd2);
        check(level == 1, "R5 level one", level, 1);
        check(ready == 1, "R5 ready", ready, 1);
        push(8'h6B, 3'd4);
        check(level == 1, "R5 second discarded", level, 1);
        check(overrun == 1, "R5 overrun", overrun, 1);
        for (int k = 0; k < 6; k++) begin tick(); idle(1); end
        check(timeout == 0, "R5 no timeout", timeout, 0);
        pop_expect(8'h5A, 3'd2, "R5 held char");
        ctl = 8'h01;
        idle(2);
    endtask

    task automatic t_timeout();
        flush(8'hC1);
        push(8'h11, 3'd0);
        idle(1);
        for (int k = 0; k < 3; k++) begin tick(); idle(1); end
        check(timeout == 0, "R7 three ticks", timeout, 0);
        tick();
        check(timeout == 1, "R7 fourth tick", timeout, 1);
        push(8'h22, 3'd0);
        check(timeout == 1, "R9 stays on arrival", timeout, 1);
        pop_expect(8'h11, 3'd0, "R9 head");
        check(timeout == 0, "R9 cleared by read", timeout, 0);
        idle(1);
        for (int k = 0; k < 3; k++) begin tick(); idle(1); end
        push(8'h33, 3'd0); // R8 restart
        for (int k = 0; k < 3; k++) begin tick(); idle(1); end
        check(timeout == 0, "R8 restart by arrival", timeout, 0);
        // R8 tick together with a read is not counted
        char_tick = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        char_tick = 1'b0; rd_en = 1'b0;
        for (int k = 0; k < 3; k++) begin tick(); idle(1); end
        check(timeout == 0, "R8 restart by read", timeout, 0);
        tick();
        check(timeout == 1, "R7 fires again", timeout, 1);
        flush(8'hC1);
        check(timeout == 0, "R6 flush clears timeout", timeout, 0);
    endtask

    task automatic t_empty_read();
        flush(8'h01);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(level == 0, "R10 level stays", level, 0);
        push(8'h77, 3'd5);
        check(level == 1, "R10 push after empty read", level, 1);
        pop_expect(8'h77, 3'd5, "R10 data intact");
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_order_full();
        t_thresholds();
        t_flush_keeps_sel();
        t_holding();
        t_timeout();
        t_empty_read();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule